// File: doc/BRIEF.md
# Capture and Autoreload Timer with Clock Output

This block is a 16-bit timer built around a running count and a second 16-bit register that does two jobs. In capture mode it holds a snapshot of the count, taken on a falling edge of an external trigger pin. In every other mode it supplies the value that is loaded into the count on overflow. One control register selects one of four modes, a prescale speed and a run bit:

- free-running capture
- up/down autoreload
- baud tick generation
- square-wave clock output

The count and reload registers are written through plain write strobes, and both are always visible on read-back outputs.

The time base comes from a prescaler that divides the clock by 12 by default, or by 4 when the fast bit is set. The baud and clock-output modes ignore the fast bit and always step every second clock. Every write to the control register restarts the prescaler. The count therefore first steps exactly D clock edges after the write, where D is the active divisor, and then steps every D edges. The count direction in autoreload mode comes from a plain input. All pins are plain control and status signals. There is no streaming interface, so no back-pressure applies.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, reload register, both flags, `baud_tick` and `clk_out` are 0, and the control register is 0: capture mode, slow prescale, stopped.
- R2: Control bits are `ctl_wdata[1:0]` mode (0 capture, 1 autoreload, 2 baud, 3 clock out), `[2]` fast, `[3]` run. In modes 0 and 1 with run set, the count steps D=12 edges after the control write and every 12 edges after that. With fast=1, D=4.
- R3: In modes 2 and 3 the count steps every 2 clock edges, whatever the fast bit says.
- R4: In capture mode the count increments and wraps from FFFFh to 0000h, and that wrap sets `ovf_flag`.
- R5: In capture mode a falling edge on `trig_in` copies the count into the reload register and sets `cap_flag`. The copy is visible after the third rising edge that samples the pin low.
- R6: A falling `trig_in` edge outside capture mode, or a rising edge in any mode, changes neither the reload register nor `cap_flag`.
- R7: In autoreload mode with `dir_up`=1, a step from FFFFh loads the reload value and sets `ovf_flag`; otherwise the step increments.
- R8: In autoreload mode with `dir_up`=0, a step from a count equal to the reload value loads FFFFh and sets `ovf_flag`; otherwise the step decrements.
- R9: In baud mode, a step from FFFFh loads the reload value and raises `baud_tick` for exactly one cycle. `ovf_flag` is not set.
- R10: In clock-output mode, a step from FFFFh loads the reload value and toggles `clk_out`. `ovf_flag` is not set.
- R11: A count write takes precedence over a step in the same cycle. A reload write takes precedence over a capture. A flag being set wins over a clear of that flag in the same cycle.
- R12: With run clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: run, fast, mode |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | New count value |
| rld_we | input | 1 | Reload/capture register write strobe |
| rld_wdata | input | 16 | New reload value |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_clr | input | 1 | Clears the capture flag |
| trig_in | input | 1 | External capture trigger pin, idle high |
| dir_up | input | 1 | Count direction in autoreload mode, 1 = up |
| cnt_q | output | 16 | Current count |
| rld_q | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| cap_flag | output | 1 | Sticky capture flag |
| baud_tick | output | 1 | One-cycle pulse per baud overflow |
| clk_out | output | 1 | Square-wave clock output |

## Verification
A wrong prescaler phase appears on `cnt_q` within one divisor period of a control write, as a step one or more edges early or late. A wrong wrap or reload rule in any mode appears on `cnt_q` and the flags on the very step that crosses the boundary. A wrong trigger pipeline shows up as the captured value arriving in `rld_q` a cycle early or late, or arriving in a mode where it must not. The bench runs a cycle-accurate arithmetic model of the requirements and compares every output on every cycle, so any such fault is reported on the cycle it first becomes visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    M_CAPT   = 2'd0,
    M_RELOAD = 2'd1,
    M_BAUD   = 2'd2,
    M_CLKOUT = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   run;
    logic   fast;
    tmode_e mode;
  } tctl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int DIV_SPEC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic spec,
  input  logic restart,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam logic [PW-1:0] L_SLOW = PW'(DIV_SLOW - 1);
  localparam logic [PW-1:0] L_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] L_SPEC = PW'(DIV_SPEC - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  always_comb begin
    if (spec)      lim = L_SPEC;
    else if (fast) lim = L_FAST;
    else           lim = L_SLOW;
  end

  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pre_q <= '0;
    else if (restart || !run || tick)  pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end

  // R3: every divisor is at least 2, so time-base ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign fall = prev_q && !sh_q[STAGES-1];

  // R5: a single falling edge yields a single capture strobe
  p_fall_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmode_e       mode,
  input  logic         dir_up,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         cap_evt,
  input  logic         ovf_clr,
  input  logic         cap_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_flag,
  output logic         cap_flag,
  output logic         baud_tick,
  output logic         clk_out
);
  logic [W-1:0] step_val;
  logic         wrap;
  logic         at_top;
  logic         at_rld;
  logic         ovf_set;
  logic         cap_set;

  assign at_top = (cnt_q == '1);
  assign at_rld = (cnt_q == rld_q);

  always_comb begin
    step_val = cnt_q + 1'b1;
    wrap     = at_top;
    case (mode)
      M_CAPT: ;
      M_RELOAD: begin
        if (dir_up) begin
          if (at_top) step_val = rld_q;
        end else begin
          wrap     = at_rld;
          step_val = at_rld ? '1 : cnt_q - 1'b1;
        end
      end
      default: if (at_top) step_val = rld_q;
    endcase
  end

  assign ovf_set = tick && wrap && (mode == M_CAPT || mode == M_RELOAD);
  assign cap_set = cap_evt && (mode == M_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      ovf_flag  <= 1'b0;
      cap_flag  <= 1'b0;
      baud_tick <= 1'b0;
      clk_out   <= 1'b0;
    end else begin
      if (cnt_we)    cnt_q <= cnt_wdata;
      else if (tick) cnt_q <= step_val;
      if (rld_we)       rld_q <= rld_wdata;
      else if (cap_set) rld_q <= cnt_q;
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (cap_set)      cap_flag <= 1'b1;
      else if (cap_clr) cap_flag <= 1'b0;
      baud_tick <= tick && wrap && (mode == M_BAUD);
      if (tick && wrap && mode == M_CLKOUT) clk_out <= !clk_out;
    end
  end

  // R9: the overflow flag only rises from capture or autoreload steps
  p_flag_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(mode) == M_CAPT || $past(mode) == M_RELOAD));
  // R9: baud tick lasts one cycle
  p_tick_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
  // R10: the output clock moves only on a clock-out mode step
  p_clk_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> ($past(mode) == M_CLKOUT && $past(tick)));
  // R5: a new capture holds the count seen just before it
  p_cap_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_flag) && !$past(rld_we)) |-> rld_q == $past(cnt_q));
  // R7: an up-count step from all ones lands on the reload value
  p_up_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !cnt_we && mode == M_RELOAD && dir_up && cnt_q == '1)
      |-> cnt_q == $past(rld_q));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SPEC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [3:0]   ctl_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         ovf_clr,
  input  logic         cap_clr,
  input  logic         trig_in,
  input  logic         dir_up,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_flag,
  output logic         cap_flag,
  output logic         baud_tick,
  output logic         clk_out
);
  tctl_t ctl_q;
  logic  tick;
  logic  fall;
  logic  spec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= tctl_t'(ctl_wdata);
  end

  assign spec = (ctl_q.mode == M_BAUD) || (ctl_q.mode == M_CLKOUT);

  tmr_prescale #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_SPEC(DIV_SPEC)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .fast(ctl_q.fast),
    .spec(spec), .restart(ctl_we), .tick(tick)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_in), .fall(fall)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctl_q.mode),
    .dir_up(dir_up), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata), .cap_evt(fall),
    .ovf_clr(ovf_clr), .cap_clr(cap_clr), .cnt_q(cnt_q), .rld_q(rld_q),
    .ovf_flag(ovf_flag), .cap_flag(cap_flag), .baud_tick(baud_tick),
    .clk_out(clk_out)
  );

  // R12: a stopped timer without a count write keeps its count
  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: tb/tb_cap_reload_timer.sv
`timescale 1ns/1ps
module tb_cap_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        rld_we = 1'b0;
  logic [15:0] rld_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic        cap_clr = 1'b0;
  logic        trig_in = 1'b1;
  logic        dir_up = 1'b1;
  logic [15:0] cnt_q, rld_q;
  logic        ovf_flag, cap_flag, baud_tick, clk_out;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ovf_clr(ovf_clr), .cap_clr(cap_clr), .trig_in(trig_in), .dir_up(dir_up),
    .cnt_q(cnt_q), .rld_q(rld_q), .ovf_flag(ovf_flag), .cap_flag(cap_flag),
    .baud_tick(baud_tick), .clk_out(clk_out)
  );

  // Arithmetic model of the requirements, one step per clock edge
  logic [3:0]  m_ctl;
  int          m_ph;
  logic        m_s1, m_s2, m_s3;
  logic [15:0] m_cnt, m_rld;
  logic        m_ovf, m_cap, m_tick, m_clk;

  always @(posedge clk or negedge rst_n) begin
    int d; bit tk, wrap, capset; logic [15:0] nx; logic [1:0] md;
    if (!rst_n) begin
      m_ctl <= '0; m_ph <= 0; m_s1 <= 1; m_s2 <= 1; m_s3 <= 1;
      m_cnt <= '0; m_rld <= '0; m_ovf <= 0; m_cap <= 0; m_tick <= 0; m_clk <= 0;
    end else begin
      md = m_ctl[1:0];
      d  = (md >= 2) ? 2 : (m_ctl[2] ? 4 : 12);
      tk = m_ctl[3] && (m_ph == d - 1);
      wrap = (m_cnt == 16'hFFFF);
      nx = m_cnt + 16'd1;
      if (md == 1 && !dir_up) begin
        wrap = (m_cnt == m_rld);
        nx = wrap ? 16'hFFFF : m_cnt - 16'd1;
      end else if (md != 0 && wrap) nx = m_rld;
      capset = (md == 0) && m_s3 && !m_s2;
      m_ph  <= (ctl_we || !m_ctl[3] || tk) ? 0 : m_ph + 1;
      if (ctl_we) m_ctl <= ctl_wdata;
      m_s1 <= trig_in; m_s2 <= m_s1; m_s3 <= m_s2;
      if (cnt_we) m_cnt <= cnt_wdata; else if (tk) m_cnt <= nx;
      if (rld_we) m_rld <= rld_wdata; else if (capset) m_rld <= m_cnt;
      if (tk && wrap && md <= 1) m_ovf <= 1; else if (ovf_clr) m_ovf <= 0;
      if (capset) m_cap <= 1; else if (cap_clr) m_cap <= 0;
      m_tick <= tk && wrap && md == 2;
      if (tk && wrap && md == 3) m_clk <= ~m_clk;
    end
  end

  function automatic string mtag(logic [3:0] c, logic up);
    case (c[1:0])
      2'd0: return "R4";
      2'd1: return up ? "R7" : "R8";
      2'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      checks++;
      if ({cnt_q, rld_q, ovf_flag, cap_flag, baud_tick, clk_out} !==
          {m_cnt, m_rld, m_ovf, m_cap, m_tick, m_clk}) begin
        errors++;
        $display("FAIL %s cycle model: act cnt=%h rld=%h f=%b%b t=%b c=%b exp cnt=%h rld=%h f=%b%b t=%b c=%b",
          mtag(m_ctl, dir_up), cnt_q, rld_q, ovf_flag, cap_flag, baud_tick, clk_out,
          m_cnt, m_rld, m_ovf, m_cap, m_tick, m_clk);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [1:0] m, logic f, logic r);
    @(negedge clk); ctl_we = 1; ctl_wdata = {r, f, m};
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_cnt(logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_rld(logic [15:0] v);
    @(negedge clk); rld_we = 1; rld_wdata = v;
    @(negedge clk); rld_we = 0;
  endtask
  task automatic clr_flags();
    @(negedge clk); ovf_clr = 1; cap_clr = 1;
    @(negedge clk); ovf_clr = 0; cap_clr = 0;
  endtask
  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic pc;
    wait_n(3);
    // R1: reset state
    chk("R1 cnt", cnt_q, 16'h0);
    chk("R1 rld", rld_q, 16'h0);
    chk("R1 flags/outs", {12'h0, ovf_flag, cap_flag, baud_tick, clk_out}, 16'h0);
    rst_n = 1;
    wait_n(2);
    chk_on = 1;
    // R1: default control is capture/slow/stopped, so a trigger edge captures
    wr_cnt(16'h0042);
    trig_in = 0; wait_n(4); trig_in = 1;
    chk("R1 default capture mode", rld_q, 16'h0042);
    chk("R12 stopped by default", cnt_q, 16'h0042);
    clr_flags();

    // R12: stopped count holds
    wr_cnt(16'h0100);
    wait_n(30);
    chk("R12 frozen", cnt_q, 16'h0100);

    // R2: slow prescale, first step 12 edges after the write
    wr_ctl(2'd0, 1'b0, 1'b1);
    wait_n(11);
    chk("R2 before 12th edge", cnt_q, 16'h0100);
    wait_n(1);
    chk("R2 at 12th edge", cnt_q, 16'h0101);
    wait_n(12);
    chk("R2 second step", cnt_q, 16'h0102);

    // R4: wrap in capture mode, fast prescale
    wr_ctl(2'd0, 1'b1, 1'b0);
    wr_cnt(16'hFFFE);
    wr_ctl(2'd0, 1'b1, 1'b1);
    wait_n(3);
    chk("R2 fast before 4th edge", cnt_q, 16'hFFFE);
    wait_n(5);
    chk("R4 wrap to zero", cnt_q, 16'h0000);
    chk("R4 ovf set", {15'h0, ovf_flag}, 16'h1);

    // R11: count write wins over a step in the same edge
    wr_ctl(2'd0, 1'b1, 1'b1);
    wait_n(3);
    cnt_we = 1; cnt_wdata = 16'h4000;
    @(negedge clk); cnt_we = 0;
    chk("R11 write beats step", cnt_q, 16'h4000);
    // R11: clear removes the overflow flag
    clr_flags();
    chk("R11 ovf cleared", {15'h0, ovf_flag}, 16'h0);

    // R5: capture while stopped, three-edge latency
    wr_ctl(2'd0, 1'b0, 1'b0);
    wr_cnt(16'h1A2B);
    wr_rld(16'h0000);
    trig_in = 0;
    wait_n(2);
    chk("R5 not yet captured", rld_q, 16'h0000);
    wait_n(1);
    chk("R5 captured value", rld_q, 16'h1A2B);
    chk("R5 cap flag", {15'h0, cap_flag}, 16'h1);
    clr_flags();
    // R6: rising edge does nothing
    trig_in = 1;
    wait_n(5);
    chk("R6 rising edge no flag", {15'h0, cap_flag}, 16'h0);
    // R6: falling edge outside capture mode ignored
    wr_ctl(2'd1, 1'b0, 1'b0);
    wr_rld(16'h5555);
    trig_in = 0; wait_n(5); trig_in = 1; wait_n(4);
    chk("R6 reload kept", rld_q, 16'h5555);
    chk("R6 no cap flag", {15'h0, cap_flag}, 16'h0);

    // R7: autoreload up
    dir_up = 1;
    wr_rld(16'h1234);
    wr_cnt(16'hFFFD);
    clr_flags();
    wr_ctl(2'd1, 1'b1, 1'b1);
    wait_n(16);
    chk("R7 reload then step", cnt_q, 16'h1235);
    chk("R7 ovf", {15'h0, ovf_flag}, 16'h1);

    // R8: autoreload down
    wr_ctl(2'd1, 1'b1, 1'b0);
    dir_up = 0;
    wr_rld(16'h0010);
    wr_cnt(16'h0013);
    clr_flags();
    wr_ctl(2'd1, 1'b1, 1'b1);
    wait_n(12);
    chk("R8 at reload value", cnt_q, 16'h0010);
    chk("R8 no ovf yet", {15'h0, ovf_flag}, 16'h0);
    wait_n(8);
    chk("R8 reload FFFF then down", cnt_q, 16'hFFFE);
    chk("R8 ovf", {15'h0, ovf_flag}, 16'h1);
    dir_up = 1;

    // R9 and R3: baud mode with fast bit clear still steps every 2 edges
    wr_ctl(2'd2, 1'b0, 1'b0);
    wr_rld(16'hFFFC);
    wr_cnt(16'hFFFC);
    clr_flags();
    wr_ctl(2'd2, 1'b0, 1'b1);
    wait_n(1);
    chk("R3 no step at edge 1", cnt_q, 16'hFFFC);
    wait_n(1);
    chk("R3 step at edge 2", cnt_q, 16'hFFFD);
    n = 0;
    for (int i = 0; i < 78; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    chk("R9 tick count", 16'(n), 16'd10);
    chk("R9 no ovf", {15'h0, ovf_flag}, 16'h0);

    // R10: clock output mode
    wr_ctl(2'd3, 1'b1, 1'b0);
    wr_rld(16'hFFFE);
    wr_cnt(16'hFFFE);
    clr_flags();
    pc = clk_out;
    wr_ctl(2'd3, 1'b1, 1'b1);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_out !== pc) n++;
      pc = clk_out;
    end
    chk("R10 toggle count", 16'(n), 16'd10);
    chk("R10 no ovf", {15'h0, ovf_flag}, 16'h0);

    // Sweep of every mode, prescale and direction near the boundaries
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int d = 0; d < 2; d++) begin
          wr_ctl(m[1:0], f[0], 1'b0);
          dir_up = d[0];
          wr_rld(d[0] ? 16'hFFF3 : 16'h0020);
          wr_cnt(d[0] ? 16'hFFF8 : 16'h0025);
          wr_ctl(m[1:0], f[0], 1'b1);
          for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            trig_in = ((c % 9) < 5);
            ovf_clr = ((c % 37) == 36);
            cap_clr = ((c % 41) == 40);
            rld_we  = ((c % 53) == 52);
            rld_wdata = 16'(16'hFFF0 + c);
          end
          @(negedge clk);
          trig_in = 1; ovf_clr = 0; cap_clr = 0; rld_we = 0;
        end

    wait_n(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule